// File: doc/BRIEF.md
# Linked Parameter-Set DMA Channel

This block is one DMA channel whose work is described by a small register file of transfer descriptors. Each descriptor holds a 32-bit source pointer, a 32-bit destination pointer, a word count, a link index and two flags. Slot 0 is the live descriptor. Each peripheral sync event, or each manual trigger from software, moves one 32-bit word. The channel reads the word at the source, writes it to the destination, advances both pointers by four bytes and lowers the count by one.

When the live count reaches zero, the descriptor named by the live link index is copied into slot 0. A chain of descriptors can therefore cover scattered buffers, and software can refill descriptors that are not live while a transfer runs. The last link index always loads a built-in null descriptor. An event that reaches a null descriptor is not served and sets a sticky missed-event flag. A dummy descriptor takes events without raising that flag.

Software uses one register port. A descriptor space holds three words per slot. A control space holds the run bit, the manual trigger, the error clear and a status read.

Top module: `lpdma_chan`

## Requirements
- R1: After reset the bus request, the interrupt and the missed flag are low, and the status word (bit 0 missed, bit 1 run, bit 2 pending) reads zero.
- R2: The register address is {space, slot, field}, with a 2-bit field. In descriptor space (space=0), field 0 is the source, field 1 is the destination and field 2 is the control word: count in bits 15:0, link in bits 19:16, interrupt enable in bit 24 and dummy in bit 25. Each field reads back what was written to it.
- R3: An event on a live descriptor with a nonzero count first reads the source word, then writes that word to the destination. Each bus request is held until it is acknowledged. After the move the source and destination have each advanced by 4 and the count has dropped by 1.
- R4: When a move brings the count to zero, slot 0 is loaded with the descriptor named by its link field. The next event uses the new pointers, which may be unrelated to the old ones.
- R5: The interrupt is a single-cycle pulse in the cycle after the final write is acknowledged, and only when the finished descriptor has its interrupt enable set.
- R6: The highest slot index (15) is the null descriptor: count 0, dummy 0. Writes to it are ignored, it always reads as zero, and linking to it loads that null content.
- R7: An event on a live null descriptor makes no bus request and sets the missed flag.
- R8: An event on a live dummy descriptor (count 0, dummy 1) makes no bus request and leaves the missed flag clear.
- R9: One event that arrives during a move is held as pending and is served once the move ends. An event that arrives while one is already pending sets the missed flag.
- R10: The missed flag stays set until software writes control-space field 2. That write also drops any pending event.
- R11: Control-space field 0 bit 0 is the run bit. While it is 0, sync events and triggers have no effect. A write of bit 0 = 1 to control-space field 1 acts as one sync event.
- R12: Descriptor writes to slots other than 0 take effect during a move. Writes to slot 0 are ignored while a move is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync_evt | input | 1 | Peripheral sync event, one event per high cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | {space, slot[3:0], field[1:0]} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | 32 | Bus read data |
| irq_tc | output | 1 | Transfer-complete pulse |
| err_missed | output | 1 | Sticky missed-event flag |

## Verification
The hardest cases to reach are the event timings around a move that is already in flight. A second event must land inside the read or write phase, and a third must land before the held one has been served. The bench pairs a memory model that acknowledges at once with sync pulses two and three cycles long, which puts events exactly in those phases. Descriptor recycling is tested the same way: a descriptor write is timed into the middle of a move, and a write to the live slot is attempted in the same window.

// File: rtl/lpdma_pkg.sv
package lpdma_pkg;

    localparam int PTR_W  = 32;
    localparam int CNT_W  = 16;
    localparam int LINK_W = 4;

    // control word bit positions
    localparam int CW_LINK_LSB = 16;
    localparam int CW_TCIE     = 24;
    localparam int CW_DUMMY    = 25;

    // descriptor field codes
    localparam logic [1:0] FLD_SRC = 2'd0;
    localparam logic [1:0] FLD_DST = 2'd1;
    localparam logic [1:0] FLD_CTL = 2'd2;

    // control-space field codes
    localparam logic [1:0] CMD_RUN  = 2'd0;
    localparam logic [1:0] CMD_TRIG = 2'd1;
    localparam logic [1:0] CMD_CLR  = 2'd2;

    typedef struct packed {
        logic [PTR_W-1:0]  src;
        logic [PTR_W-1:0]  dst;
        logic [CNT_W-1:0]  cnt;
        logic [LINK_W-1:0] link;
        logic              tcie;
        logic              dummy;
    } pset_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_t;

    function automatic pset_t null_pset();
        pset_t p;
        p = '0;
        return p;
    endfunction

    function automatic logic [31:0] ctl_word(pset_t p);
        logic [31:0] w;
        w = '0;
        w[CNT_W-1:0] = p.cnt;
        w[CW_LINK_LSB +: LINK_W] = p.link;
        w[CW_TCIE] = p.tcie;
        w[CW_DUMMY] = p.dummy;
        return w;
    endfunction

endpackage

// File: rtl/lpdma_pset_ram.sv
module lpdma_pset_ram
    import lpdma_pkg::*;
#(
    parameter int NSETS = 16,
    parameter int IDX_W = $clog2(NSETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_fld,
    input  logic [31:0]       cfg_wdata,
    input  logic              busy,
    input  logic              eng_we,
    input  pset_t             eng_val,
    output pset_t             set0,
    output pset_t             link_set,
    output pset_t             rd_set
);

    localparam int NULL_IDX = NSETS - 1;
    localparam logic [IDX_W-1:0] NULL_SEL = IDX_W'(NULL_IDX);

    pset_t ps_q [NSETS-1];
    pset_t ps_d [NSETS-1];

    logic [IDX_W-1:0] lk;
    logic             cfg_ok;
    logic             unused_bits;

    assign unused_bits = ^{cfg_wdata[31:CW_DUMMY+1],
                           cfg_wdata[CW_TCIE-1:CW_LINK_LSB+LINK_W]};

    function automatic pset_t put_field(pset_t p, logic [1:0] f, logic [31:0] w);
        pset_t r;
        r = p;
        case (f)
            FLD_SRC: r.src = w;
            FLD_DST: r.dst = w;
            FLD_CTL: begin
                r.cnt   = w[CNT_W-1:0];
                r.link  = w[CW_LINK_LSB +: LINK_W];
                r.tcie  = w[CW_TCIE];
                r.dummy = w[CW_DUMMY];
            end
            default: r = p;
        endcase
        return r;
    endfunction

    // software may not touch the null slot, nor slot 0 while a move runs
    assign cfg_ok = cfg_we && (cfg_idx < NULL_SEL)
                    && !((cfg_idx == '0) && (busy || eng_we));

    always_comb begin
        for (int i = 0; i < NSETS - 1; i++) ps_d[i] = ps_q[i];
        if (cfg_ok) ps_d[cfg_idx] = put_field(ps_q[cfg_idx], cfg_fld, cfg_wdata);
        if (eng_we) ps_d[0] = eng_val;
    end

    for (genvar g = 0; g < NSETS - 1; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ps_q[g] <= null_pset();
            else        ps_q[g] <= ps_d[g];
        end
    end

    assign lk       = set0.link[IDX_W-1:0];
    assign set0     = ps_q[0];
    assign link_set = (lk >= NULL_SEL) ? null_pset() : ps_q[lk];
    assign rd_set   = (cfg_idx >= NULL_SEL) ? null_pset() : ps_q[cfg_idx];

    AST_SLOT0_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_we) |=> $stable(ps_q[0])); // R12

endmodule

// File: rtl/lpdma_engine.sv
module lpdma_engine
    import lpdma_pkg::*;
#(
    parameter int STEP = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        evt,
    input  logic        clr,
    input  pset_t       set0,
    input  pset_t       link_set,
    output logic        eng_we,
    output pset_t       eng_val,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        irq,
    output logic        missed,
    output logic        pend
);

    typedef struct packed {
        eng_st_t     st;
        logic [31:0] data;
        logic        pend;
        logic        missed;
        logic        irq;
    } eng_s;

    eng_s q, d;
    logic evt_g;
    logic serve;

    always_comb begin
        d       = q;
        d.irq   = 1'b0;
        eng_we  = 1'b0;
        eng_val = set0;
        evt_g   = evt && run;
        serve   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (run) begin
                    if (q.pend) begin
                        serve  = 1'b1;
                        d.pend = evt_g;
                    end else if (evt_g) begin
                        serve = 1'b1;
                    end
                end
                if (serve) begin
                    if (set0.cnt != '0)   d.st = ST_RD;
                    else if (!set0.dummy) d.missed = 1'b1;
                end
            end
            ST_RD: begin
                if (evt_g) begin
                    if (q.pend) d.missed = 1'b1;
                    else        d.pend = 1'b1;
                end
                if (mem_ack) begin
                    d.data = mem_rdata;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (evt_g) begin
                    if (q.pend) d.missed = 1'b1;
                    else        d.pend = 1'b1;
                end
                if (mem_ack) begin
                    eng_we = 1'b1;
                    if (set0.cnt == CNT_W'(1)) begin
                        eng_val = link_set;
                        d.irq   = set0.tcie;
                    end else begin
                        eng_val.src = set0.src + PTR_W'(STEP);
                        eng_val.dst = set0.dst + PTR_W'(STEP);
                        eng_val.cnt = set0.cnt - CNT_W'(1);
                    end
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (clr) begin
            d.missed = 1'b0;
            d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, data: '0, pend: 1'b0, missed: 1'b0, irq: 1'b0};
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (q.st == ST_WR);
    assign mem_addr  = mem_we ? set0.dst : set0.src;
    assign mem_wdata = q.data;
    assign irq       = q.irq;
    assign missed    = q.missed;
    assign pend      = q.pend;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R3
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack)); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5
    AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_we && mem_ack)); // R5
    AST_NULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && set0.cnt == '0) |=> !mem_req); // R7
    AST_DUMMY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && set0.cnt == '0 && set0.dummy && !missed) |=> !missed); // R8
    AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (missed && !clr) |=> missed); // R10
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && q.st == ST_IDLE) |=> !mem_req); // R11

endmodule

// File: rtl/lpdma_cfg.sv
module lpdma_cfg
    import lpdma_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int ADR_W = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [ADR_W-1:0] cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  pset_t            rd_set,
    input  logic             missed,
    input  logic             pend,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_idx,
    output logic [1:0]       ram_fld,
    output logic             trig,
    output logic             clr,
    output logic             run,
    output logic [31:0]      cfg_rdata
);

    typedef struct packed {
        logic run;
    } cfg_s;

    cfg_s q, d;
    logic ctl_space;
    logic unused_bits;

    assign unused_bits = ^cfg_wdata[31:1];
    assign ctl_space = cfg_addr[ADR_W-1];
    assign ram_idx   = cfg_addr[IDX_W+1:2];
    assign ram_fld   = cfg_addr[1:0];
    assign ram_we    = cfg_we && !ctl_space;
    assign trig      = cfg_we && ctl_space && (ram_fld == CMD_TRIG) && cfg_wdata[0];
    assign clr       = cfg_we && ctl_space && (ram_fld == CMD_CLR);

    always_comb begin
        d = q;
        if (cfg_we && ctl_space && ram_fld == CMD_RUN) d.run = cfg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{run: 1'b0};
        else        q <= d;
    end

    assign run = q.run;

    always_comb begin
        cfg_rdata = '0;
        if (ctl_space) begin
            cfg_rdata[2:0] = {pend, q.run, missed};
        end else begin
            case (ram_fld)
                FLD_SRC: cfg_rdata = rd_set.src;
                FLD_DST: cfg_rdata = rd_set.dst;
                FLD_CTL: cfg_rdata = ctl_word(rd_set);
                default: cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/lpdma_chan.sv
module lpdma_chan
    import lpdma_pkg::*;
#(
    parameter int NSETS = 16,
    parameter int STEP  = 4,
    localparam int IDX_W = $clog2(NSETS),
    localparam int ADR_W = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_evt,
    input  logic             cfg_we,
    input  logic [ADR_W-1:0] cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             irq_tc,
    output logic             err_missed
);

    pset_t            set0, link_set, rd_set, eng_val;
    logic             eng_we, busy, run, trig, clr, pend;
    logic             ram_we;
    logic [IDX_W-1:0] ram_idx;
    logic [1:0]       ram_fld;

    lpdma_cfg #(.IDX_W(IDX_W), .ADR_W(ADR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_set(rd_set), .missed(err_missed), .pend(pend),
        .ram_we(ram_we), .ram_idx(ram_idx), .ram_fld(ram_fld), .trig(trig),
        .clr(clr), .run(run), .cfg_rdata(cfg_rdata)
    );

    lpdma_pset_ram #(.NSETS(NSETS), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .cfg_we(ram_we), .cfg_idx(ram_idx),
        .cfg_fld(ram_fld), .cfg_wdata(cfg_wdata), .busy(busy), .eng_we(eng_we),
        .eng_val(eng_val), .set0(set0), .link_set(link_set), .rd_set(rd_set)
    );

    lpdma_engine #(.STEP(STEP)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .evt(sync_evt || trig), .clr(clr),
        .set0(set0), .link_set(link_set), .eng_we(eng_we), .eng_val(eng_val),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq(irq_tc), .missed(err_missed), .pend(pend)
    );

endmodule

// File: tb/tb_lpdma_chan.sv
`timescale 1ns/1ps
module tb_lpdma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_evt = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we, mem_ack, irq_tc, err_missed;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:255];
    int n_wr = 0;
    int n_irq = 0;
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    lpdma_chan dut (
        .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_tc(irq_tc), .err_missed(err_missed)
    );

    // memory model: acknowledges in the cycle of the request
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
        end else begin
            if (mem_req && mem_we) begin
                mem[mem_addr[9:2]] = mem_wdata;
                n_wr++;
            end
            if (irq_tc) n_irq++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int cnt, input int link, input bit tcie, input bit dmy);
        return {6'd0, dmy, tcie, 4'd0, 4'(link), 16'(cnt)};
    endfunction

    task automatic wr(input bit sp, input int idx, input int fld, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = {sp, 4'(idx), 2'(fld)};
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input bit sp, input int idx, input int fld, output logic [31:0] v);
        cfg_addr = {sp, 4'(idx), 2'(fld)};
        #1;
        v = cfg_rdata;
    endtask

    task automatic set_wr(input int idx, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        wr(0, idx, 0, s);
        wr(0, idx, 1, d);
        wr(0, idx, 2, c);
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        sync_evt = 1'b1;
        repeat (n) @(negedge clk);
        sync_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 irq", {31'd0, irq_tc}, 0);
        chk("R1 missed", {31'd0, err_missed}, 0);
        rd(1, 0, 0, v);
        chk("R1 status", v, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        set_wr(3, 32'h1234_5678, 32'h9ABC_DEF0, cw(16'hAB, 5, 1, 0));
        rd(0, 3, 0, v); chk("R2 src", v, 32'h1234_5678);
        rd(0, 3, 1, v); chk("R2 dst", v, 32'h9ABC_DEF0);
        rd(0, 3, 2, v); chk("R2 ctl", v, 32'h0105_00AB);
        wr(0, 15, 2, cw(7, 3, 1, 1));
        rd(0, 15, 2, v); chk("R6 null slot ignores write", v, 0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        int w0;
        set_wr(0, 32'h100, 32'h200, cw(2, 2, 0, 0));
        set_wr(2, 32'h300, 32'h040, cw(1, 15, 1, 0));
        wr(1, 0, 0, 1);
        pulse(1); idle(4);
        chk("R3 first word", mem[128], 32'hA000_0040);
        rd(0, 0, 0, v); chk("R3 src step", v, 32'h104);
        rd(0, 0, 1, v); chk("R3 dst step", v, 32'h204);
        rd(0, 0, 2, v); chk("R3 count", v, cw(1, 2, 0, 0));
        pulse(1); idle(4);
        chk("R3 second word", mem[129], 32'hA000_0041);
        rd(0, 0, 0, v); chk("R4 reload src", v, 32'h300);
        chk("R5 no irq when disabled", 32'(n_irq), 0);
        pulse(1);
        @(negedge clk); chk("R5 irq not early", {31'd0, irq_tc}, 0);
        @(negedge clk); chk("R5 irq pulse", {31'd0, irq_tc}, 1);
        @(negedge clk); chk("R5 irq single", {31'd0, irq_tc}, 0);
        chk("R4 word from linked set", mem[16], 32'hA000_00C0);
        rd(0, 0, 2, v); chk("R6 null loaded", v, 0);
        w0 = n_wr;
        pulse(1); idle(4);
        chk("R7 no bus on null", 32'(n_wr - w0), 0);
        chk("R7 missed set", {31'd0, err_missed}, 1);
        idle(3);
        chk("R10 missed sticky", {31'd0, err_missed}, 1);
        wr(1, 0, 2, 0);
        chk("R10 cleared", {31'd0, err_missed}, 0);
    endtask

    task automatic t_dummy();
        int w0;
        wr(0, 0, 2, cw(0, 15, 0, 1));
        w0 = n_wr;
        pulse(1); idle(4);
        chk("R8 no bus on dummy", 32'(n_wr - w0), 0);
        chk("R8 no missed", {31'd0, err_missed}, 0);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        int w0;
        set_wr(0, 32'h000, 32'h080, cw(3, 15, 0, 0));
        w0 = n_wr;
        pulse(2); idle(8);
        chk("R9 held event served", 32'(n_wr - w0), 2);
        chk("R9 no missed", {31'd0, err_missed}, 0);
        rd(0, 0, 2, v); chk("R9 count", v, cw(1, 15, 0, 0));
        wr(0, 0, 2, cw(5, 15, 0, 0));
        w0 = n_wr;
        pulse(3); idle(8);
        chk("R9 overflow missed", {31'd0, err_missed}, 1);
        chk("R9 two moves", 32'(n_wr - w0), 2);
        rd(1, 0, 0, v); chk("R9 status", v, 32'h3);
        wr(1, 0, 2, 0);
        rd(1, 0, 0, v); chk("R10 clear status", v, 32'h2);
    endtask

    task automatic t_clear_pending();
        logic [31:0] v;
        int w0;
        set_wr(0, 32'h000, 32'h0A0, cw(4, 15, 0, 0));
        w0 = n_wr;
        pulse(2);
        // pending now held, clear it while the first move is in its write phase
        cfg_we = 1'b1; cfg_addr = {1'b1, 4'd0, 2'd2}; cfg_wdata = 0;
        @(negedge clk); cfg_we = 1'b0;
        idle(6);
        chk("R10 clear drops pending", 32'(n_wr - w0), 1);
        rd(1, 0, 0, v); chk("R10 pending clear", v, 32'h2);
    endtask

    task automatic t_run_gate();
        logic [31:0] v;
        int w0;
        set_wr(0, 32'h000, 32'h0E0, cw(2, 15, 0, 0));
        wr(1, 0, 0, 0);
        w0 = n_wr;
        pulse(1); wr(1, 0, 1, 1); idle(4);
        chk("R11 stopped ignores", 32'(n_wr - w0), 0);
        wr(0, 0, 2, 0);
        pulse(1); idle(3);
        chk("R11 stopped no missed", {31'd0, err_missed}, 0);
        wr(0, 0, 2, cw(2, 15, 0, 0));
        wr(1, 0, 0, 1);
        wr(1, 0, 1, 1); idle(4);
        chk("R11 trigger moves one", 32'(n_wr - w0), 1);
        chk("R11 trigger data", mem[56], 32'hA000_0000);
        rd(0, 0, 2, v); chk("R11 count", v, cw(1, 15, 0, 0));
    endtask

    task automatic t_recycle();
        logic [31:0] v;
        set_wr(0, 32'h000, 32'h0C0, cw(2, 4, 0, 0));
        set_wr(4, 32'h010, 32'h0D0, cw(9, 15, 0, 0));
        pulse(1);
        // move in read phase: slot 0 write must be ignored
        cfg_we = 1'b1; cfg_addr = {1'b1 ^ 1'b1, 4'd0, 2'd1}; cfg_wdata = 32'hFFC;
        @(negedge clk);
        // move in write phase: rewrite slot 4 count
        cfg_addr = {1'b0, 4'd4, 2'd2}; cfg_wdata = cw(1, 15, 0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        idle(3);
        rd(0, 0, 1, v); chk("R12 slot0 locked", v, 32'h0C4);
        pulse(1); idle(4);
        rd(0, 0, 0, v); chk("R12 recycled src", v, 32'h010);
        rd(0, 0, 2, v); chk("R12 recycled ctl", v, cw(1, 15, 0, 0));
    endtask

    initial begin : watchdog
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regmap();
        t_chain();
        t_dummy();
        t_pending();
        t_clear_pending();
        t_run_gate();
        t_recycle();
        idle(2);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule